// File: doc/BRIEF.md
# BLE Beacon Transmit Sequencer

This controller drives a small 2.4 GHz transceiver, reached through a byte-wide SPI master, so that it sends raw frames a Bluetooth Low Energy scanner accepts as advertisements. A `start` pulse runs a fixed setup program. The program turns off the radio's own CRC, acknowledgement and retransmission, sets a 4-byte access address, and fixes the receive length at 32 bytes.

After setup, each accepted 16-byte message is placed into a 32-byte advertising frame, and that frame is sent on the three advertising channels in turn. For each channel the sequencer:

- tunes the radio;
- clears its flags;
- hands the frame to an external CRC/whitening encoder and waits for it;
- flushes both FIFOs;
- streams the encoded 32 bytes;
- rewrites the mode register;
- holds chip-enable high for a fixed number of clock cycles.

The SPI shifter sits outside this block. It shifts `spi_byte` while `spi_valid` is high and pulses `spi_ready` for one cycle when the byte has gone out. The sequencer owns the active-low chip-select and drops it for exactly one command at a time.

The controller is a single state machine. Its states are:

- `S_IDLE`: waiting.
- `S_FRAME`: chip-select low, bytes being shifted.
- `S_GAP`: one cycle with chip-select high, where the next command is chosen.
- `S_ENC_GO`: the encoder trigger cycle.
- `S_ENC_WAIT`: waiting for the encoder to finish.
- `S_CE`: chip-enable high.
- `S_DONE`: the one-cycle completion state.

Its transitions are:

- idle→frame on an accepted start or message;
- frame→gap on the last byte's `spi_ready`;
- gap→frame for the next command;
- gap→enc_go after the flag-clear command;
- enc_go→enc_wait unconditionally;
- enc_wait→frame on `enc_done`;
- gap→ce after the mode write;
- ce→frame on timer expiry for the next channel;
- ce→done after the third channel;
- gap→done after the last setup command;
- done→idle unconditionally.

Top module: `ble_beacon_seq`

## Requirements
- R1: After reset, `cs_n`=1, `ce`=0, `spi_valid`=0, `enc_start`=0, `busy`=0 and `done`=0.
- R2: Each command is one chip-select frame: `cs_n` is low for all its bytes, `spi_valid` is only high while `cs_n` is low, and `cs_n` is high for at least one cycle between commands. A register write is the byte 0x20|address followed by its data bytes.
- R3: A `start` pulse taken in idle sends these register writes, in this order, as (address,data): (0x00,0x12), (0x01,0x00), (0x02,0x00), (0x03,0x02), (0x04,0x00), (0x06,0x06), (0x07,0x3E), (0x1C,0x00), (0x1D,0x00), (0x11,0x20), (0x02,0x01).
- R4: The setup then writes address 0x10 and then address 0x0A, each with 4 data bytes: the bit-reversed 0x8E, 0x89, 0xBE, 0xD6, which are 0x71, 0x91, 0x7D, 0x6B.
- R5: `msg_valid` is ignored until one setup has completed. `start` and `msg_valid` are ignored while `busy` is high.
- R6: While the encoder is triggered, `frame_out` byte i (bits 8i+7..8i) holds the following, for 32 bytes in all:
    - byte 0 is 0x42;
    - byte 1 is 0x1B;
    - bytes 2..7 are `DEV_MAC` bytes 0..5, least significant byte first;
    - bytes 8..10 are 0x02, 0x01, 0x05;
    - byte 11 is 0x11;
    - byte 12 is 0x08;
    - bytes 13..28 are message bytes 0..15, where byte k is `msg_data[8k+7:8k]`;
    - bytes 29..31 are 0x55.
- R7: Every message is sent on channels 37, 38 and 39, in that order. Each channel starts with a write to address 0x05 of radio channel 2, 26 or 80 respectively, and `enc_chan` carries the advertising channel number.
- R8: Each channel sends, in order:
    - the channel write;
    - a write of 0x6E to address 0x07;
    - the encoder handshake;
    - the single byte 0xE1;
    - the single byte 0xE2;
    - 0xA0 followed by the 32 bytes of `enc_frame`, byte 0 (bits 7..0) first;
    - a write of 0x12 to address 0x00.
- R9: `enc_start` is a one-cycle pulse after the flag-clear command. No SPI byte is requested from then until `enc_done` is seen.
- R10: `ce` rises only after a channel's final mode write, stays high for exactly `CE_CYCLES` clock cycles, and no SPI activity occurs while it is high.
- R11: `busy` is high from the cycle after an accepted `start` or message until the cycle after `done`. `done` is a one-cycle pulse at the end of setup and at the end of each message's third channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Run the setup program |
| msg_valid | input | 1 | Message present on msg_data |
| msg_data | input | 128 | 16 message bytes, byte 0 in bits 7..0 |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| spi_valid | output | 1 | Byte request to the SPI shifter |
| spi_byte | output | 8 | Byte to shift |
| spi_ready | input | 1 | Byte shifted, one-cycle pulse |
| cs_n | output | 1 | Radio chip-select, active low |
| ce | output | 1 | Radio chip-enable |
| enc_start | output | 1 | Encoder trigger pulse |
| enc_chan | output | 6 | Advertising channel for the encoder |
| frame_out | output | 256 | Assembled plain frame |
| enc_frame | input | 256 | Encoded frame held by the encoder |
| enc_done | input | 1 | Encoder finished, one-cycle pulse |

## Verification
The hardest places to reach are the pauses inside a channel: the wait on the encoder and the chip-enable window. In both, the SPI side must go quiet even though the shifter would accept bytes at any time. The bench supplies an encoder model that answers several cycles late and returns a channel-dependent transform of the frame it captured. It also shortens `CE_CYCLES` so that each window is short and its length can be measured exactly. Because the model's output differs per channel, a payload streamed before the encoder finished, or taken from the wrong channel, shows up as wrong bytes. Message and start pulses are also injected during an active message and before setup, to reach the ignore paths.

// File: rtl/ble_seq_pkg.sv
package ble_seq_pkg;

    localparam int FRAME_BYTES = 32;
    localparam int MSG_BYTES   = 16;
    localparam int MAC_BYTES   = 6;
    localparam int NUM_CHANS   = 3;
    localparam int CFG_FRAMES  = 13;
    localparam int FIRST_ADV   = 37;

    // radio register addresses
    localparam logic [4:0] RA_MODE   = 5'h00;
    localparam logic [4:0] RA_ACK    = 5'h01;
    localparam logic [4:0] RA_RXEN   = 5'h02;
    localparam logic [4:0] RA_AWID   = 5'h03;
    localparam logic [4:0] RA_RETRY  = 5'h04;
    localparam logic [4:0] RA_CHAN   = 5'h05;
    localparam logic [4:0] RA_RFCFG  = 5'h06;
    localparam logic [4:0] RA_FLAGS  = 5'h07;
    localparam logic [4:0] RA_RXA0   = 5'h0A;
    localparam logic [4:0] RA_TXA    = 5'h10;
    localparam logic [4:0] RA_RXLEN0 = 5'h11;
    localparam logic [4:0] RA_DYNLEN = 5'h1C;
    localparam logic [4:0] RA_FEAT   = 5'h1D;

    // single-byte radio commands
    localparam logic [7:0] OP_FLUSH_TX = 8'hE1;
    localparam logic [7:0] OP_FLUSH_RX = 8'hE2;
    localparam logic [7:0] OP_LOAD_TX  = 8'hA0;

    // per-channel command slots
    localparam logic [3:0] CH_TUNE  = 4'd0;
    localparam logic [3:0] CH_CLEAR = 4'd1;
    localparam logic [3:0] CH_FLTX  = 4'd2;
    localparam logic [3:0] CH_FLRX  = 4'd3;
    localparam logic [3:0] CH_LOAD  = 4'd4;
    localparam logic [3:0] CH_MODE  = 4'd5;

    typedef enum logic [2:0] {
        S_IDLE, S_FRAME, S_GAP, S_ENC_GO, S_ENC_WAIT, S_CE, S_DONE
    } seq_state_t;

    typedef enum logic {PROG_CFG, PROG_CHAN} prog_t;

    function automatic logic [7:0] bitrev8(input logic [7:0] a);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = a[7-i];
        return r;
    endfunction

    function automatic logic [7:0] wr_cmd(input logic [4:0] addr);
        return {3'b001, addr};
    endfunction

    // access address bytes before bit reversal
    function automatic logic [7:0] access_byte(input logic [1:0] k);
        case (k)
            2'd0:    return 8'h8E;
            2'd1:    return 8'h89;
            2'd2:    return 8'hBE;
            default: return 8'hD6;
        endcase
    endfunction

    function automatic logic [7:0] rf_of(input logic [1:0] c);
        case (c)
            2'd0:    return 8'd2;
            2'd1:    return 8'd26;
            default: return 8'd80;
        endcase
    endfunction

endpackage

// File: rtl/ble_frame_asm.sv
module ble_frame_asm
    import ble_seq_pkg::*;
#(
    parameter logic [8*MAC_BYTES-1:0] DEV_MAC = 48'h0
) (
    input  logic [8*MSG_BYTES-1:0]   msg,
    output logic [8*FRAME_BYTES-1:0] frame
);
    localparam int MAC_OFS = 2;
    localparam int MSG_OFS = 13;
    localparam int SEED_OFS = MSG_OFS + MSG_BYTES;

    assign frame[7:0]    = 8'h42;
    assign frame[15:8]   = 8'h1B;
    assign frame[8*8 +: 8]  = 8'h02;
    assign frame[8*9 +: 8]  = 8'h01;
    assign frame[8*10 +: 8] = 8'h05;
    assign frame[8*11 +: 8] = 8'h11;
    assign frame[8*12 +: 8] = 8'h08;

    for (genvar m = 0; m < MAC_BYTES; m++) begin : g_mac
        assign frame[8*(MAC_OFS+m) +: 8] = DEV_MAC[8*m +: 8];
    end

    for (genvar k = 0; k < MSG_BYTES; k++) begin : g_msg
        assign frame[8*(MSG_OFS+k) +: 8] = msg[8*k +: 8];
    end

    for (genvar s = SEED_OFS; s < FRAME_BYTES; s++) begin : g_seed
        assign frame[8*s +: 8] = 8'h55;
    end
endmodule

// File: rtl/ble_cmd_rom.sv
module ble_cmd_rom
    import ble_seq_pkg::*;
(
    input  prog_t                    prog,
    input  logic [3:0]               fidx,
    input  logic [5:0]               bidx,
    input  logic [1:0]               chan,
    input  logic [8*FRAME_BYTES-1:0] enc_frame,
    output logic [7:0]               byte_o,
    output logic [5:0]               len_o
);
    logic [7:0] cmd;
    logic [7:0] dat;
    logic [4:0] pidx;
    logic [1:0] aidx;

    assign pidx = bidx[4:0] - 5'd1;
    assign aidx = pidx[1:0];

    always_comb begin
        cmd   = 8'h00;
        dat   = 8'h00;
        len_o = 6'd2;
        if (prog == PROG_CFG) begin
            unique case (fidx)
                4'd0:    begin cmd = wr_cmd(RA_MODE);   dat = 8'h12; end
                4'd1:    begin cmd = wr_cmd(RA_ACK);    dat = 8'h00; end
                4'd2:    begin cmd = wr_cmd(RA_RXEN);   dat = 8'h00; end
                4'd3:    begin cmd = wr_cmd(RA_AWID);   dat = 8'h02; end
                4'd4:    begin cmd = wr_cmd(RA_RETRY);  dat = 8'h00; end
                4'd5:    begin cmd = wr_cmd(RA_RFCFG);  dat = 8'h06; end
                4'd6:    begin cmd = wr_cmd(RA_FLAGS);  dat = 8'h3E; end
                4'd7:    begin cmd = wr_cmd(RA_DYNLEN); dat = 8'h00; end
                4'd8:    begin cmd = wr_cmd(RA_FEAT);   dat = 8'h00; end
                4'd9:    begin cmd = wr_cmd(RA_RXLEN0); dat = 8'd32; end
                4'd10:   begin cmd = wr_cmd(RA_RXEN);   dat = 8'h01; end
                4'd11:   begin cmd = wr_cmd(RA_TXA);  dat = bitrev8(access_byte(aidx)); len_o = 6'd5; end
                default: begin cmd = wr_cmd(RA_RXA0); dat = bitrev8(access_byte(aidx)); len_o = 6'd5; end
            endcase
        end else begin
            unique case (fidx)
                CH_TUNE:  begin cmd = wr_cmd(RA_CHAN);  dat = rf_of(chan); end
                CH_CLEAR: begin cmd = wr_cmd(RA_FLAGS); dat = 8'h6E; end
                CH_FLTX:  begin cmd = OP_FLUSH_TX; len_o = 6'd1; end
                CH_FLRX:  begin cmd = OP_FLUSH_RX; len_o = 6'd1; end
                CH_LOAD:  begin cmd = OP_LOAD_TX; dat = enc_frame[8*pidx +: 8];
                                len_o = 6'(FRAME_BYTES + 1); end
                default:  begin cmd = wr_cmd(RA_MODE);  dat = 8'h12; end
            endcase
        end
    end

    assign byte_o = (bidx == 6'd0) ? cmd : dat;
endmodule

// File: rtl/ble_ce_timer.sv
module ble_ce_timer #(
    parameter int CYCLES = 1000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);
    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt <= '0;
        else if (!run) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end

    assign expire = run && (cnt == LAST);

    // R10: the window never runs past its length
    p_ce_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !expire) |=> (cnt != '0));
endmodule

// File: rtl/ble_beacon_seq.sv
module ble_beacon_seq
    import ble_seq_pkg::*;
#(
    parameter int                    CE_CYCLES = 1000000,
    parameter logic [8*MAC_BYTES-1:0] DEV_MAC  = 48'hC2_11_22_33_44_55
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     msg_valid,
    input  logic [8*MSG_BYTES-1:0]   msg_data,
    output logic                     busy,
    output logic                     done,
    output logic                     spi_valid,
    output logic [7:0]               spi_byte,
    input  logic                     spi_ready,
    output logic                     cs_n,
    output logic                     ce,
    output logic                     enc_start,
    output logic [5:0]               enc_chan,
    output logic [8*FRAME_BYTES-1:0] frame_out,
    input  logic [8*FRAME_BYTES-1:0] enc_frame,
    input  logic                     enc_done
);
    localparam logic [3:0] CFG_LAST  = 4'(CFG_FRAMES - 1);
    localparam logic [1:0] CHAN_LAST = 2'(NUM_CHANS - 1);

    seq_state_t st, st_n;
    prog_t      prog, prog_n;
    logic [3:0] fidx, fidx_n;
    logic [5:0] bidx, bidx_n;
    logic [1:0] chan, chan_n;
    logic       cfg_ok, cfg_ok_n;
    logic [8*MSG_BYTES-1:0] msg_q, msg_n;
    logic [7:0] rom_byte;
    logic [5:0] rom_len;
    logic       ce_expire;

    ble_frame_asm #(.DEV_MAC(DEV_MAC)) u_asm (
        .msg   (msg_q),
        .frame (frame_out)
    );

    ble_cmd_rom u_rom (
        .prog      (prog),
        .fidx      (fidx),
        .bidx      (bidx),
        .chan      (chan),
        .enc_frame (enc_frame),
        .byte_o    (rom_byte),
        .len_o     (rom_len)
    );

    ble_ce_timer #(.CYCLES(CE_CYCLES)) u_ce (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (st == S_CE),
        .expire (ce_expire)
    );

    // next-state logic
    always_comb begin
        st_n     = st;
        prog_n   = prog;
        fidx_n   = fidx;
        bidx_n   = bidx;
        chan_n   = chan;
        cfg_ok_n = cfg_ok;
        msg_n    = msg_q;
        unique case (st)
            S_IDLE: begin
                if (start) begin
                    prog_n = PROG_CFG;
                    fidx_n = '0;
                    bidx_n = '0;
                    st_n   = S_FRAME;
                end else if (msg_valid && cfg_ok) begin
                    msg_n  = msg_data;
                    prog_n = PROG_CHAN;
                    chan_n = '0;
                    fidx_n = CH_TUNE;
                    bidx_n = '0;
                    st_n   = S_FRAME;
                end
            end
            S_FRAME: begin
                if (spi_ready) begin
                    if (bidx == rom_len - 6'd1) begin
                        bidx_n = '0;
                        st_n   = S_GAP;
                    end else begin
                        bidx_n = bidx + 6'd1;
                    end
                end
            end
            S_GAP: begin
                if (prog == PROG_CFG) begin
                    if (fidx == CFG_LAST) begin
                        cfg_ok_n = 1'b1;
                        st_n     = S_DONE;
                    end else begin
                        fidx_n = fidx + 4'd1;
                        st_n   = S_FRAME;
                    end
                end else if (fidx == CH_CLEAR) begin
                    fidx_n = CH_FLTX;
                    st_n   = S_ENC_GO;
                end else if (fidx == CH_MODE) begin
                    st_n = S_CE;
                end else begin
                    fidx_n = fidx + 4'd1;
                    st_n   = S_FRAME;
                end
            end
            S_ENC_GO:   st_n = S_ENC_WAIT;
            S_ENC_WAIT: if (enc_done) st_n = S_FRAME;
            S_CE: begin
                if (ce_expire) begin
                    if (chan == CHAN_LAST) begin
                        st_n = S_DONE;
                    end else begin
                        chan_n = chan + 2'd1;
                        fidx_n = CH_TUNE;
                        st_n   = S_FRAME;
                    end
                end
            end
            S_DONE:  st_n = S_IDLE;
            default: st_n = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= S_IDLE;
            prog   <= PROG_CFG;
            fidx   <= '0;
            bidx   <= '0;
            chan   <= '0;
            cfg_ok <= 1'b0;
            msg_q  <= '0;
        end else begin
            st     <= st_n;
            prog   <= prog_n;
            fidx   <= fidx_n;
            bidx   <= bidx_n;
            chan   <= chan_n;
            cfg_ok <= cfg_ok_n;
            msg_q  <= msg_n;
        end
    end

    // outputs
    always_comb begin
        spi_valid = (st == S_FRAME);
        cs_n      = (st != S_FRAME);
        spi_byte  = rom_byte;
        ce        = (st == S_CE);
        enc_start = (st == S_ENC_GO);
        enc_chan  = 6'(FIRST_ADV) + {4'd0, chan};
        busy      = (st != S_IDLE);
        done      = (st == S_DONE);
    end

    // R2: bytes are requested only inside a chip-select frame
    p_valid_in_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
        spi_valid |-> !cs_n);
    // R2: a finished command releases chip-select before the next
    p_cs_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_ready && !cs_n && (bidx == rom_len - 6'd1)) |=> cs_n);
    // R9: no SPI request right after the encoder trigger
    p_enc_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        enc_start |=> (!spi_valid && !enc_start));
    // R7: the encoder only sees advertising channels
    p_chan_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        enc_start |-> (enc_chan >= 6'd37 && enc_chan <= 6'd39));
    // R10: SPI is idle while chip-enable is high
    p_ce_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ce |-> (cs_n && !spi_valid));
    // R11: done is a single-cycle pulse raised while busy
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);
    // R5: a message before setup leaves the block idle
    p_early_msg_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start && msg_valid && !cfg_ok) |=> !busy);
endmodule

// File: tb/ble_beacon_seq_tb.sv
module ble_beacon_seq_tb;
    localparam int CE_N = 20;
    localparam logic [47:0] MAC = 48'hA1B2C3D4E5F6;

    logic clk = 0;
    logic rst_n = 0;
    logic start = 0, msg_valid = 0;
    logic [127:0] msg_data = '0;
    logic busy, done, spi_valid, cs_n, ce, enc_start;
    logic [7:0] spi_byte;
    logic spi_ready = 0;
    logic [5:0] enc_chan;
    logic [255:0] frame_out;
    logic [255:0] enc_frame = '0;
    logic enc_done = 0;

    always #5 clk = ~clk;

    ble_beacon_seq #(.CE_CYCLES(CE_N), .DEV_MAC(MAC)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .msg_valid(msg_valid),
        .msg_data(msg_data), .busy(busy), .done(done), .spi_valid(spi_valid),
        .spi_byte(spi_byte), .spi_ready(spi_ready), .cs_n(cs_n), .ce(ce),
        .enc_start(enc_start), .enc_chan(enc_chan), .frame_out(frame_out),
        .enc_frame(enc_frame), .enc_done(enc_done)
    );

    int checks = 0, errors = 0;

    // captured activity
    logic [7:0] got_b[$];
    bit         got_f[$];
    logic [7:0] exp_b[$];
    bit         exp_f[$];
    int ce_len[$], ce_at[$];
    logic [255:0] cap_frame[$];
    int cap_chan[$];
    int done_cnt = 0, enc_spi = 0;

    // SPI shifter, encoder and observers
    int  spi_cnt = 0, ce_run = 0, enc_cnt = 0;
    bit  new_frame = 1, in_enc = 0;
    always @(negedge clk) begin
        if (spi_ready) spi_ready = 0;
        else if (spi_valid) begin
            if (spi_cnt == 2) begin
                spi_ready = 1; spi_cnt = 0;
                got_b.push_back(spi_byte); got_f.push_back(new_frame);
                new_frame = 0;
            end else spi_cnt++;
        end
        if (cs_n) new_frame = 1;
        if (done) done_cnt++;
        if (ce) begin
            if (ce_run == 0) ce_at.push_back(got_b.size());
            ce_run++;
        end else if (ce_run != 0) begin
            ce_len.push_back(ce_run); ce_run = 0;
        end
        if (enc_done) begin enc_done = 0; in_enc = 0; end
        if (in_enc && spi_valid) enc_spi++;
        if (enc_start) begin
            cap_frame.push_back(frame_out);
            cap_chan.push_back(int'(enc_chan));
            enc_frame = frame_out ^ {32{2'b00, enc_chan}};
            enc_cnt = 4; in_enc = 1;
        end else if (enc_cnt != 0) begin
            enc_cnt--;
            if (enc_cnt == 0) enc_done = 1;
        end
    end

    function automatic logic [7:0] rev(input logic [7:0] a);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = a[7-i];
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] b, input bit f);
        exp_b.push_back(b); exp_f.push_back(f);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        put(8'h20 | a, 1); put(d, 0);
    endtask

    function automatic logic [7:0] fbyte(input logic [127:0] m, input int i);
        if (i == 0) return 8'h42;
        if (i == 1) return 8'h1B;
        if (i < 8)  return MAC[8*(i-2) +: 8];
        if (i == 8) return 8'h02;
        if (i == 9) return 8'h01;
        if (i == 10) return 8'h05;
        if (i == 11) return 8'd17;
        if (i == 12) return 8'h08;
        if (i < 29) return m[8*(i-13) +: 8];
        return 8'h55;
    endfunction

    task automatic cmp_stream(input string req);
        chk(got_b.size() == exp_b.size(), req, got_b.size(), exp_b.size());
        for (int i = 0; i < exp_b.size() && i < got_b.size(); i++) begin
            chk(got_b[i] == exp_b[i], req, got_b[i], exp_b[i]);
            chk(got_f[i] == exp_f[i], "R2", got_f[i], exp_f[i]);
        end
    endtask

    task automatic wait_done(input int n, input string req);
        int lim = 0;
        while (done_cnt < n && lim < 20000) begin @(negedge clk); lim++; end
        if (lim >= 20000) chk(0, {req, " watchdog"}, done_cnt, n);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(cs_n == 1 && ce == 0 && spi_valid == 0, "R1", {cs_n, ce, spi_valid}, 3'b100);
        chk(enc_start == 0 && busy == 0 && done == 0, "R1", {enc_start, busy, done}, 0);
    endtask

    task automatic t_early_msg();
        msg_valid = 1; msg_data = '1;
        @(negedge clk); msg_valid = 0;
        repeat (30) @(negedge clk);
        chk(busy == 0, "R5 early msg busy", busy, 0);
        chk(got_b.size() == 0, "R5 early msg bytes", got_b.size(), 0);
    endtask

    task automatic t_config();
        logic [7:0] aw[4] = '{8'h8E, 8'h89, 8'hBE, 8'hD6};
        wr(8'h00, 8'h12); wr(8'h01, 8'h00); wr(8'h02, 8'h00); wr(8'h03, 8'h02);
        wr(8'h04, 8'h00); wr(8'h06, 8'h06); wr(8'h07, 8'h3E); wr(8'h1C, 8'h00);
        wr(8'h1D, 8'h00); wr(8'h11, 8'h20); wr(8'h02, 8'h01);
        put(8'h30, 1); foreach (aw[i]) put(rev(aw[i]), 0);
        put(8'h2A, 1); foreach (aw[i]) put(rev(aw[i]), 0);
        start = 1; @(negedge clk); start = 0;
        chk(busy == 1, "R11 busy after start", busy, 1);
        start = 1; @(negedge clk); start = 0;   // ignored while busy (R5)
        wait_done(1, "R3");
        @(negedge clk);
        chk(busy == 0, "R11 idle after done", busy, 0);
        chk(done_cnt == 1, "R11 done count", done_cnt, 1);
        cmp_stream("R3/R4");
    endtask

    task automatic t_message(input logic [127:0] m);
        int base = exp_b.size(), ce0 = ce_len.size(), cf0 = cap_frame.size();
        int d0 = done_cnt;
        logic [255:0] pf;
        for (int i = 0; i < 32; i++) pf[8*i +: 8] = fbyte(m, i);
        for (int c = 0; c < 3; c++) begin
            logic [7:0] rf = (c == 0) ? 8'd2 : (c == 1) ? 8'd26 : 8'd80;
            wr(8'h05, rf); wr(8'h07, 8'h6E);
            put(8'hE1, 1); put(8'hE2, 1); put(8'hA0, 1);
            for (int i = 0; i < 32; i++) put(pf[8*i +: 8] ^ 8'(37 + c), 0);
            wr(8'h00, 8'h12);
        end
        msg_data = m; msg_valid = 1; @(negedge clk); msg_valid = 0;
        msg_data = '0;
        repeat (3) @(negedge clk);
        chk(busy == 1, "R11 busy in message", busy, 1);
        msg_valid = 1; start = 1; @(negedge clk); msg_valid = 0; start = 0; // R5
        wait_done(d0 + 1, "R8");
        @(negedge clk);
        chk(busy == 0, "R11 idle after message", busy, 0);
        chk(done_cnt == d0 + 1, "R11 one done per message", done_cnt, d0 + 1);
        repeat (30) @(negedge clk);
        chk(done_cnt == d0 + 1 && busy == 0, "R5 no second run", done_cnt, d0 + 1);
        cmp_stream("R7/R8");
        chk(enc_spi == 0, "R9 spi during encode", enc_spi, 0);
        for (int c = 0; c < 3; c++) begin
            chk(cap_chan[cf0 + c] == 37 + c, "R7 enc_chan", cap_chan[cf0 + c], 37 + c);
            chk(cap_frame[cf0 + c] == pf, "R6 frame_out", cap_frame[cf0 + c][31:0], pf[31:0]);
            chk(ce_len[ce0 + c] == CE_N, "R10 ce length", ce_len[ce0 + c], CE_N);
            chk(ce_at[ce0 + c] == base + 41 * (c + 1), "R10 ce after mode write",
                ce_at[ce0 + c], base + 41 * (c + 1));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        t_reset();
        t_early_msg();
        t_config();
        t_message(128'h0F0E0D0C0B0A09080706050403020100);
        t_message(128'hDEADBEEF_5A5AA5A5_FFFF0000_13579BDF);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule